// File: doc/BRIEF.md
# SD Host Command Issue Engine

This block is the command half of an SD host controller. Software first loads a 32-bit argument. It then writes a 16-bit command word, and that write starts the command. The engine builds a 48-bit command frame from the command index and the argument, protected by CRC7. It shifts the frame out MSB first on a serial command line model, one bit per clock. It then listens for the card's reply, which can be absent, 48 bits long or 136 bits long.

The engine keeps two inhibit flags that software polls before it issues the next command. It latches the card's reply into a 128-bit response field. It reports command completion and three error causes in two write-one-to-clear status words: no start bit in time, a bad CRC7 and a wrong echoed index. For replies with a busy phase, the data inhibit flag stays set until the card releases DAT0. The data path and the card itself are outside this block.

Top module: `sdcmd_issuer`

## Requirements
- R1: Each accepted command drives `cmd_oe` high for exactly 48 clocks. During those clocks `cmd_out` carries the frame MSB first: start bit 0, direction bit 1, the 6-bit index, the 32-bit argument, CRC7 (polynomial x^7+x^3+1, computed over the first 40 bits) and end bit 1. For example, index 0 with argument 0 gives 0x400000000095.
- R2: Command word fields: index in bits 13:8, index check enable in bit 4, CRC check enable in bit 3, reply kind in bits 1:0. The reply kinds are 00 none, 01 136-bit, 10 48-bit and 11 48-bit followed by busy.
- R3: `present_state[0]` (command inhibit) is set by an accepted command word write. It clears when the reply ends, when the end bit is sent (no reply) or on timeout. A command word written while it is set is ignored and sends no frame.
- R4: A command with reply kind 00 sets `nrm_status[0]` (complete) when its end bit has gone out.
- R5: A 48-bit reply sets `nrm_status[0]` and places reply bits 39:8 in `resp_data[31:0]`, with the upper bits zero.
- R6: A 136-bit reply sets `nrm_status[0]` and places reply bits 127:8 in `resp_data[119:0]`, with bits 127:120 zero. The CRC byte is dropped and no index or CRC check applies.
- R7: If no start bit arrives within 64 clocks after the end bit, `err_status[0]` and `nrm_status[15]` are set and `nrm_status[0]` is not. A start bit as late as the 63rd clock is still accepted.
- R8: With CRC checking enabled, a 48-bit reply whose CRC7 does not match sets `err_status[1]`. With checking disabled, the mismatch has no effect.
- R9: With index checking enabled, a 48-bit reply whose index field (bits 45:40) differs from the command index sets `err_status[3]`. With checking disabled, the difference has no effect.
- R10: Reply kind 11 sets `present_state[1]` (data inhibit) together with the command inhibit. Data inhibit holds after the reply until `dat_in[0]` is sampled high. `present_state[23:20]` always shows `dat_in`, and all other bits are zero.
- R11: Status bits clear when a 1 is written to the matching bit of the clear masks on `sts_clr_wr`. `nrm_status[15]` is the OR of `err_status` and is not cleared directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the command line bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_wr | input | 1 | Command word write strobe; starts a command |
| cmd_wdata | input | 16 | Command word |
| sts_clr_wr | input | 1 | Status clear strobe |
| nrm_clr_mask | input | 16 | Write-one-to-clear mask for the normal status |
| err_clr_mask | input | 16 | Write-one-to-clear mask for the error status |
| cmd_in | input | 1 | Serial reply from the card |
| dat_in | input | 4 | DAT line levels |
| cmd_out | output | 1 | Serial command output |
| cmd_oe | output | 1 | Command output enable |
| present_state | output | 32 | Inhibit flags and DAT line levels |
| nrm_status | output | 16 | Completion bit 0 and error summary bit 15 |
| err_status | output | 16 | Timeout bit 0, CRC bit 1, index bit 3 |
| resp_data | output | 128 | Captured reply contents |

## Verification
A sequencer that lost its place would show on the command line within one frame. The length check on `cmd_oe` and the comparison of each frame against the queued expected frame would fail, and so would the end-bit check. A receiver that counted wrongly shows the reply shifted in `resp_data` as soon as the inhibit drops, or shows a spurious CRC or index error. A wrong inhibit or busy flag shows within a clock in `present_state`: either a second frame escapes while a command is still running, or data inhibit falls while DAT0 is still low.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

   // reply kind carried in the low two bits of the command word
   typedef enum logic [1:0] {
      RSP_NONE  = 2'b00,
      RSP_LONG  = 2'b01,
      RSP_SHORT = 2'b10,
      RSP_BUSY  = 2'b11
   } rsp_kind_e;

   localparam int CRC_IN_W      = 40;
   localparam int CMD_IDX_LSB   = 8;
   localparam int CMD_CHK_IDX   = 4;
   localparam int CMD_CHK_CRC   = 3;
   localparam int ERR_TMO_BIT   = 0;
   localparam int ERR_CRC_BIT   = 1;
   localparam int ERR_IDX_BIT   = 3;

   // CRC7, generator x^7 + x^3 + 1, MSB first, zero seed
   function automatic logic [6:0] crc7(input logic [CRC_IN_W-1:0] d);
      logic [6:0] c;
      logic       fb;
      c = '0;
      for (int i = CRC_IN_W - 1; i >= 0; i--) begin
         fb = d[i] ^ c[6];
         c  = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

endpackage

// File: rtl/sdcmd_tx.sv
`timescale 1ns/1ps
module sdcmd_tx #(
   parameter int FRAME_W = 48
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   output logic               ser_out,
   output logic               ser_oe,
   output logic               last
);
   localparam int CNT_W = $clog2(FRAME_W);

   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   cnt;
   logic               busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         busy <= 1'b0;
      end else if (load && !busy) begin
         sh   <= frame;
         cnt  <= CNT_W'(FRAME_W - 1);
         busy <= 1'b1;
      end else if (busy) begin
         sh <= {sh[FRAME_W-2:0], 1'b1};
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign ser_out = busy ? sh[FRAME_W-1] : 1'b1;
   assign ser_oe  = busy;
   assign last    = busy && (cnt == '0);

endmodule

// File: rtl/sdcmd_rx.sv
`timescale 1ns/1ps
module sdcmd_rx #(
   parameter int SHORT_BITS = 48,
   parameter int LONG_BITS  = 136,
   parameter int TIMEOUT    = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 listen,
   input  logic                 long_sel,
   input  logic                 ser_in,
   output logic                 done,
   output logic                 tmo,
   output logic [LONG_BITS-1:0] data
);
   localparam int RC_W = $clog2(LONG_BITS);
   localparam int TC_W = $clog2(TIMEOUT + 1);

   typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_RECV} rx_state_e;

   rx_state_e          st;
   logic [RC_W-1:0]    rcnt;
   logic [TC_W-1:0]    wcnt;
   logic               long_q;
   logic [RC_W-1:0]    last_idx;

   assign last_idx = long_q ? RC_W'(LONG_BITS - 1) : RC_W'(SHORT_BITS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         rcnt   <= '0;
         wcnt   <= '0;
         long_q <= 1'b0;
         done   <= 1'b0;
         tmo    <= 1'b0;
         data   <= '0;
      end else begin
         done <= 1'b0;
         tmo  <= 1'b0;
         unique case (st)
            RX_IDLE: if (listen) begin
               st     <= RX_WAIT;
               wcnt   <= '0;
               long_q <= long_sel;
            end
            RX_WAIT: if (!ser_in) begin
               data <= {data[LONG_BITS-2:0], 1'b0};
               rcnt <= RC_W'(1);
               st   <= RX_RECV;
            end else if (wcnt == TC_W'(TIMEOUT - 1)) begin
               tmo <= 1'b1;
               st  <= RX_IDLE;
            end else begin
               wcnt <= wcnt + 1'b1;
            end
            RX_RECV: begin
               data <= {data[LONG_BITS-2:0], ser_in};
               if (rcnt == last_idx) begin
                  done <= 1'b1;
                  st   <= RX_IDLE;
               end else begin
                  rcnt <= rcnt + 1'b1;
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sdcmd_issuer.sv
`timescale 1ns/1ps
module sdcmd_issuer #(
   parameter int ARG_W        = 32,
   parameter int IDX_W        = 6,
   parameter int RESP_TIMEOUT = 64,
   parameter int SHORT_BITS   = 48,
   parameter int LONG_BITS    = 136
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  arg_wr,
   input  logic [ARG_W-1:0]      arg_wdata,
   input  logic                  cmd_wr,
   input  logic [15:0]           cmd_wdata,
   input  logic                  sts_clr_wr,
   input  logic [15:0]           nrm_clr_mask,
   input  logic [15:0]           err_clr_mask,
   input  logic                  cmd_in,
   input  logic [3:0]            dat_in,
   output logic                  cmd_out,
   output logic                  cmd_oe,
   output logic [31:0]           present_state,
   output logic [15:0]           nrm_status,
   output logic [15:0]           err_status,
   output logic [LONG_BITS-9:0]  resp_data
);
   import sdcmd_pkg::*;

   localparam int FRAME_W  = IDX_W + ARG_W + 10;
   localparam int RESP_W   = LONG_BITS - 8;
   localparam int CRC_SPAN = SHORT_BITS - 8;

   generate
      if (FRAME_W != SHORT_BITS) begin : g_bad_frame
         $error("command frame and short reply must be equal length");
      end
      if (CRC_SPAN != CRC_IN_W) begin : g_bad_crc
         $error("CRC7 span does not match the short reply");
      end
      if (RESP_TIMEOUT < 2) begin : g_bad_tmo
         $error("reply timeout must be at least two clocks");
      end
      if (LONG_BITS <= SHORT_BITS + 8) begin : g_bad_long
         $error("long reply must exceed the short reply");
      end
   endgenerate

   logic [ARG_W-1:0]     arg_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 chk_idx_q, chk_crc_q;
   rsp_kind_e            kind_q, wr_kind;
   logic                 cmd_inh, dat_inh, busy_wait, cc_q;
   logic [15:0]          err_q, err_set;
   logic [RESP_W-1:0]    resp_q;
   logic                 accept, tx_last, rx_done, rx_tmo, phase_end, no_rsp_end;
   logic [FRAME_W-1:0]   frame;
   logic [LONG_BITS-1:0] rx_data;
   logic [IDX_W-1:0]     wr_idx;
   logic                 crc_bad, idx_bad, short_kind;

   assign wr_kind    = rsp_kind_e'(cmd_wdata[1:0]);
   assign wr_idx     = cmd_wdata[CMD_IDX_LSB +: IDX_W];
   assign accept     = cmd_wr && !cmd_inh;
   assign frame      = {2'b01, wr_idx, arg_q,
                        crc7({2'b01, wr_idx, arg_q}), 1'b1};
   assign no_rsp_end = tx_last && (kind_q == RSP_NONE);
   assign phase_end  = rx_done || rx_tmo;
   assign short_kind = kind_q[1];

   sdcmd_tx #(.FRAME_W(FRAME_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(accept), .frame(frame),
      .ser_out(cmd_out), .ser_oe(cmd_oe), .last(tx_last)
   );

   sdcmd_rx #(.SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS),
              .TIMEOUT(RESP_TIMEOUT)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .listen(tx_last && (kind_q != RSP_NONE)),
      .long_sel(kind_q == RSP_LONG), .ser_in(cmd_in),
      .done(rx_done), .tmo(rx_tmo), .data(rx_data)
   );

   assign crc_bad = crc7(rx_data[SHORT_BITS-1:8]) != rx_data[7:1];
   assign idx_bad = rx_data[SHORT_BITS-3 -: IDX_W] != idx_q;

   always_comb begin
      err_set              = '0;
      err_set[ERR_TMO_BIT] = rx_tmo;
      err_set[ERR_CRC_BIT] = rx_done && short_kind && chk_crc_q && crc_bad;
      err_set[ERR_IDX_BIT] = rx_done && short_kind && chk_idx_q && idx_bad;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arg_q     <= '0;
         idx_q     <= '0;
         chk_idx_q <= 1'b0;
         chk_crc_q <= 1'b0;
         kind_q    <= RSP_NONE;
         cmd_inh   <= 1'b0;
         dat_inh   <= 1'b0;
         busy_wait <= 1'b0;
         cc_q      <= 1'b0;
         err_q     <= '0;
         resp_q    <= '0;
      end else begin
         if (arg_wr) arg_q <= arg_wdata;
         if (accept) begin
            idx_q     <= wr_idx;
            chk_idx_q <= cmd_wdata[CMD_CHK_IDX];
            chk_crc_q <= cmd_wdata[CMD_CHK_CRC];
            kind_q    <= wr_kind;
         end
         if (accept)                               cmd_inh <= 1'b1;
         else if (no_rsp_end || phase_end)         cmd_inh <= 1'b0;
         if (accept && (wr_kind == RSP_BUSY))      dat_inh <= 1'b1;
         else if (busy_wait && dat_in[0])          dat_inh <= 1'b0;
         if (phase_end && (kind_q == RSP_BUSY))    busy_wait <= 1'b1;
         else if (busy_wait && dat_in[0])          busy_wait <= 1'b0;
         if (no_rsp_end || rx_done)                cc_q <= 1'b1;
         else if (sts_clr_wr && nrm_clr_mask[0])   cc_q <= 1'b0;
         err_q <= (err_q & ~(sts_clr_wr ? err_clr_mask : 16'h0000)) | err_set;
         if (rx_done) begin
            if (kind_q == RSP_LONG) resp_q <= RESP_W'(rx_data[LONG_BITS-9:8]);
            else                    resp_q <= RESP_W'(rx_data[SHORT_BITS-9:8]);
         end
      end
   end

   assign present_state = {8'h00, dat_in, 18'h0, dat_inh, cmd_inh};
   assign nrm_status    = {|err_q, 14'h0, cc_q};
   assign err_status    = err_q;
   assign resp_data     = resp_q;

   logic unused_bits;
   assign unused_bits = ^{cmd_wdata[15:14], cmd_wdata[7:5], cmd_wdata[2],
                          nrm_clr_mask[15:1], rx_data[LONG_BITS-1:LONG_BITS-8],
                          rx_data[0]};

endmodule

// File: rtl/sdcmd_issuer_chk.sv
`timescale 1ns/1ps
module sdcmd_issuer_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_out,
   input logic cmd_oe,
   input logic cmd_busy,
   input logic dat_busy,
   input logic done_flag,
   input logic err_sum,
   input logic tmo_flag,
   input logic dat0
);
   // R1
   frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_oe) |-> !cmd_out);
   // R1
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_oe) |-> $past(cmd_out));
   // R3
   oe_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> cmd_busy);
   // R4 R5
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> !cmd_busy);
   // R7
   tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> (!cmd_busy && err_sum));
   // R10
   dat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_busy) |-> cmd_busy);
   // R10
   dat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dat_busy) |-> $past(dat0));
endmodule

bind sdcmd_issuer sdcmd_issuer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
   .cmd_busy(present_state[0]), .dat_busy(present_state[1]),
   .done_flag(nrm_status[0]), .err_sum(nrm_status[15]),
   .tmo_flag(err_status[0]), .dat0(dat_in[0])
);

// File: tb/sdcmd_issuer_bench.sv
`timescale 1ns/1ps
module sdcmd_issuer_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         arg_wr = 1'b0, cmd_wr = 1'b0, sts_clr_wr = 1'b0, cmd_in = 1'b1;
   logic [31:0]  arg_wdata = '0;
   logic [15:0]  cmd_wdata = '0, nrm_clr_mask = '0, err_clr_mask = '0;
   logic [3:0]   dat_in = 4'hF;
   logic         cmd_out, cmd_oe;
   logic [31:0]  present_state;
   logic [15:0]  nrm_status, err_status;
   logic [127:0] resp_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [47:0] exp_frames[$];

   always #2.5 clk = ~clk;

   sdcmd_issuer u_sdcmd_issuer (
      .clk(clk), .rst_n(rst_n), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
      .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .sts_clr_wr(sts_clr_wr),
      .nrm_clr_mask(nrm_clr_mask), .err_clr_mask(err_clr_mask),
      .cmd_in(cmd_in), .dat_in(dat_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
      .present_state(present_state), .nrm_status(nrm_status),
      .err_status(err_status), .resp_data(resp_data)
   );

   task automatic chk_eq(input string tag, input logic [135:0] act, input logic [135:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] ref_crc(input logic [39:0] d);
      logic [6:0] c = '0;
      for (int i = 39; i >= 0; i--) begin
         logic top = c[6] ^ d[i];
         c = {c[5:0], 1'b0} ^ (top ? 7'h09 : 7'h00);
      end
      return c;
   endfunction

   function automatic logic [47:0] mk_frame(input logic [5:0] idx, input logic [31:0] arg);
      return {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
   endfunction

   function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] st);
      return 136'({2'b00, idx, st, ref_crc({2'b00, idx, st}), 1'b1});
   endfunction

   // command word: index 13:8, index check 4, CRC check 3, reply kind 1:0
   function automatic logic [15:0] cw(input logic [5:0] idx, input logic ci,
                                      input logic cc, input logic [1:0] rt);
      return {2'b00, idx, 3'b000, ci, cc, 1'b0, rt};
   endfunction

   // scoreboard monitor: every frame on the line is popped and compared
   initial begin
      logic [47:0] fr = '0;
      int nb = 0;
      forever begin
         @(negedge clk);
         if (cmd_oe) begin
            fr = {fr[46:0], cmd_out};
            nb++;
         end else if (nb != 0) begin
            if (exp_frames.size() == 0)
               chk_eq("R3 frame sent while none expected", 136'(fr), 136'(0));
            else
               chk_eq("R1 frame contents", 136'(fr), 136'(exp_frames.pop_front()));
            chk_eq("R1 frame length", 136'(nb), 136'(48));
            nb = 0;
         end
      end
   end

   task automatic write_cmd(input logic [31:0] arg, input logic [15:0] w);
      @(negedge clk); arg_wr = 1'b1; arg_wdata = arg;
      @(negedge clk); arg_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = w;
      @(negedge clk); cmd_wr = 1'b0;
   endtask

   task automatic wait_frame_end();
      do @(negedge clk); while (cmd_oe);
   endtask

   task automatic card_send(input int gap, input logic [135:0] bits, input int len);
      repeat (gap) @(negedge clk);
      for (int i = len - 1; i >= 0; i--) begin
         cmd_in = bits[i];
         @(negedge clk);
      end
      cmd_in = 1'b1;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (present_state[0] && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic clear(input logic [15:0] nm, input logic [15:0] em);
      @(negedge clk); sts_clr_wr = 1'b1; nrm_clr_mask = nm; err_clr_mask = em;
      @(negedge clk); sts_clr_wr = 1'b0; nrm_clr_mask = '0; err_clr_mask = '0;
   endtask

   task automatic short_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic ci,
                            input logic cc, input logic [135:0] rsp, input int gap);
      exp_frames.push_back(mk_frame(idx, arg));
      write_cmd(arg, cw(idx, ci, cc, 2'b10));
      wait_frame_end();
      card_send(gap, rsp, 48);
      wait_idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R3, R10, R11)
      chk_eq("R10 reset present state", 136'(present_state), 136'(32'h00F0_0000));
      chk_eq("R11 reset normal status", 136'(nrm_status), 136'(0));
      chk_eq("R11 reset error status", 136'(err_status), 136'(0));
      chk_eq("R3 reset line idle", 136'(cmd_oe), 136'(0));
      chk_eq("R1 bench CRC7 reference", 136'(ref_crc(40'h40_0000_0000)), 136'(7'h4A));

      // R4: no reply, known frame for index 0 / argument 0
      exp_frames.push_back(48'h40_0000_0000_95);
      write_cmd(32'h0, cw(6'd0, 1'b0, 1'b0, 2'b00));
      chk_eq("R3 inhibit set on write", 136'(present_state[0]), 136'(1));
      wait_frame_end();
      chk_eq("R4 complete after end bit", 136'(nrm_status), 136'(16'h0001));
      chk_eq("R4 inhibit released", 136'(present_state[0]), 136'(0));
      clear(16'h0001, 16'h0);
      chk_eq("R11 complete cleared", 136'(nrm_status), 136'(0));

      // R5: 48-bit reply, both checks on
      exp_frames.push_back(mk_frame(6'd17, 32'h0000_0200));
      write_cmd(32'h0000_0200, cw(6'd17, 1'b1, 1'b1, 2'b10));
      wait_frame_end();
      chk_eq("R3 inhibit held while awaiting reply", 136'(present_state[0]), 136'(1));
      card_send(2, short_rsp(6'd17, 32'h0000_0900), 48);
      wait_idle();
      chk_eq("R5 status word", 136'(resp_data), 136'(32'h0000_0900));
      chk_eq("R5 complete", 136'(nrm_status), 136'(16'h0001));
      chk_eq("R5 no error", 136'(err_status), 136'(0));
      clear(16'hFFFF, 16'hFFFF);

      // R3: second write during a running command is dropped
      exp_frames.push_back(48'h48_0000_01AA_87);
      write_cmd(32'h0000_01AA, cw(6'd8, 1'b1, 1'b1, 2'b10));
      write_cmd(32'h0, cw(6'd5, 1'b0, 1'b0, 2'b00));
      wait_frame_end();
      card_send(3, short_rsp(6'd8, 32'h0000_01AA), 48);
      wait_idle();
      chk_eq("R5 echo argument", 136'(resp_data), 136'(32'h0000_01AA));
      repeat (80) @(negedge clk);
      chk_eq("R3 ignored write sent nothing", 136'(exp_frames.size()), 136'(0));
      chk_eq("R3 inhibit clear", 136'(present_state[0]), 136'(0));
      clear(16'hFFFF, 16'hFFFF);

      // R8: bad CRC with and without checking
      short_cmd(6'd13, 32'h1234_0000, 1'b0, 1'b1, short_rsp(6'd13, 32'h0000_0700) ^ 136'h2, 4);
      chk_eq("R8 CRC error flagged", 136'(err_status), 136'(16'h0002));
      chk_eq("R11 summary follows error", 136'(nrm_status), 136'(16'h8001));
      clear(16'h8001, 16'h0);
      chk_eq("R11 summary not directly clearable", 136'(nrm_status), 136'(16'h8000));
      clear(16'h0, 16'h0002);
      chk_eq("R11 error cleared", 136'(err_status), 136'(0));
      chk_eq("R11 summary drops", 136'(nrm_status), 136'(16'h0000));
      short_cmd(6'd13, 32'h1234_0000, 1'b1, 1'b0, short_rsp(6'd13, 32'h0000_0700) ^ 136'h2, 4);
      chk_eq("R8 CRC ignored when disabled", 136'(err_status), 136'(0));
      clear(16'hFFFF, 16'hFFFF);

      // R9: wrong index with and without checking
      short_cmd(6'd17, 32'h0, 1'b1, 1'b1, short_rsp(6'd3, 32'h0000_0900), 2);
      chk_eq("R9 index error flagged", 136'(err_status), 136'(16'h0008));
      clear(16'hFFFF, 16'hFFFF);
      short_cmd(6'd17, 32'h0, 1'b0, 1'b1, short_rsp(6'd3, 32'h0000_0900), 2);
      chk_eq("R9 index ignored when disabled", 136'(err_status), 136'(0));
      clear(16'hFFFF, 16'hFFFF);

      // R6: 136-bit reply, CRC byte stripped
      begin
         logic [119:0] pay = {60'h0123_4567_89AB_CDE, 60'hFED_CBA9_8765_4321};
         exp_frames.push_back(mk_frame(6'd2, 32'h0));
         write_cmd(32'h0, cw(6'd2, 1'b1, 1'b1, 2'b01));
         wait_frame_end();
         card_send(5, {2'b00, 6'h3F, pay, 7'h55, 1'b1}, 136);
         wait_idle();
         chk_eq("R6 long reply contents", 136'(resp_data), 136'({8'h00, pay}));
         chk_eq("R6 no check errors", 136'(err_status), 136'(0));
         chk_eq("R6 complete", 136'(nrm_status), 136'(16'h0001));
      end
      clear(16'hFFFF, 16'hFFFF);

      // R7: late start bit still accepted, later one times out
      short_cmd(6'd9, 32'h0001_0000, 1'b1, 1'b1, short_rsp(6'd9, 32'h0000_0ABC), 62);
      chk_eq("R7 late reply accepted", 136'(resp_data), 136'(32'h0000_0ABC));
      chk_eq("R7 no timeout", 136'(err_status), 136'(0));
      clear(16'hFFFF, 16'hFFFF);
      short_cmd(6'd9, 32'h0001_0000, 1'b1, 1'b1, short_rsp(6'd9, 32'h0000_0DEF), 66);
      chk_eq("R7 timeout flagged", 136'(err_status), 136'(16'h0001));
      chk_eq("R7 summary without complete", 136'(nrm_status), 136'(16'h8000));
      chk_eq("R7 late reply not captured", 136'(resp_data), 136'(32'h0000_0ABC));
      chk_eq("R7 inhibit released", 136'(present_state[0]), 136'(0));
      clear(16'hFFFF, 16'hFFFF);

      // R10: busy reply holds data inhibit until DAT0 rises
      dat_in = 4'hE;
      exp_frames.push_back(mk_frame(6'd7, 32'h1234_0000));
      write_cmd(32'h1234_0000, cw(6'd7, 1'b1, 1'b1, 2'b11));
      chk_eq("R10 data inhibit set", 136'(present_state), 136'(32'h00E0_0003));
      wait_frame_end();
      card_send(3, short_rsp(6'd7, 32'h0000_0700), 48);
      wait_idle();
      repeat (5) @(negedge clk);
      chk_eq("R10 held while DAT0 low", 136'(present_state), 136'(32'h00E0_0002));
      chk_eq("R2 R5 busy reply stored", 136'(resp_data), 136'(32'h0000_0700));
      dat_in = 4'hF;
      @(negedge clk);
      chk_eq("R10 released after DAT0 high", 136'(present_state), 136'(32'h00F0_0000));

      repeat (10) @(negedge clk);
      chk_eq("R1 all frames seen", 136'(exp_frames.size()), 136'(0));
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule